// File: doc/BRIEF.md
# Microcontroller Reset Sequencer with Power-On Clock Gating

This block produces the reset and clock-gating controls for a small 8-bit microcontroller core. The core runs on an oscillator clock, and each machine cycle spans twelve oscillator periods. The block takes three inputs:

- an external reset pin, which is asynchronous to the clock but already noise-qualified;
- a power-good indication;
- a static option that enables power-on handling.

From these it drives the CPU reset, a CPU clock enable, a port reset control, and forced-high levels for the address-latch and program-fetch strobes.

The pin passes through a synchroniser. It is then sampled once per machine cycle, at one fixed phase slot. A reset from the pin needs two consecutive high samples. Once asserted, that reset holds until the first sample that reads low. After power becomes good, and with the power-on option enabled, the CPU clock stays gated off and the CPU stays in reset for 1536 oscillator periods. If power-good drops, the whole sequence restarts at once.

Top module: `mcu_reset_seq`

## Requirements
- R1: A phase counter runs 0 to 11 and wraps. It starts at 0 on the first clock edge after power-good rises. The synchronised pin is sampled only on the clock edge at which the phase count is 9. A pin level applied before edge k is first seen by a sample on edge k+2.
- R2: The CPU reset from the pin asserts on the second of two consecutive high samples. A single high sample, followed by a low one, leaves the CPU reset deasserted.
- R3: Once asserted by the pin, the CPU reset stays asserted while the samples remain high. It clears on the first sample that reads low, provided the power-on interval has ended.
- R4: The port reset output is high whenever the pin is high, with no clock edge in between, and also whenever the CPU reset is high.
- R5: The address-latch and program-fetch force outputs are both high exactly when the CPU reset is high.
- R6: With the power-on option set to 1, the CPU clock enable is low and the CPU reset is high for the first 1535 clock edges after power-good rises. Both release after edge 1536, unless the pin holds the reset.
- R7: With the power-on option set to 0, the clock enable is always high. The CPU reset then depends on the pin alone, including during the 1536 edges that follow power-good.
- R8: A low power-good immediately, without a clock edge, drops the clock enable and asserts the CPU reset when the power-on option is set. The 1536-edge count then restarts from zero when power-good returns.
- R9: If the pin is held high across the end of the power-on interval, the CPU reset remains asserted without a gap. It clears at the first low sample after the pin falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| pwr_good | input | 1 | Power-good indication, active high; low resets all state asynchronously |
| por_enable | input | 1 | Static option: 1 enables power-on gating |
| rst_pin | input | 1 | Noise-qualified external reset pin, asynchronous |
| cpu_rst | output | 1 | Internal CPU reset, active high |
| cpu_clk_en | output | 1 | CPU clock enable |
| port_rst | output | 1 | Port reset control, active high |
| ale_force | output | 1 | Forces the address-latch strobe high |
| psen_force | output | 1 | Forces the program-fetch strobe high |

## Verification
A wrong phase count or synchroniser depth moves the cycle in which the CPU reset rises or falls by one sampling slot or more. For most pulse start offsets this is caught within one machine cycle of the pulse. A miscounted high-sample run shows up as a reset on pulses of only one slot, or as a missing reset on pulses of two slots. Sweeping pulse length against start phase exposes every such boundary. An error in the power-on counter appears as a clock enable that rises one or more edges away from edge 1536. A restart that is not asynchronous leaves the clock enable high for a moment after power-good falls.

// File: rtl/mcu_reset_seq.sv
module mcu_reset_seq #(
  parameter int PHASES       = 12,
  parameter int SAMPLE_PHASE = 9,
  parameter int POR_PERIODS  = 1536,
  parameter int MIN_HIGH     = 2,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic pwr_good,
  input  logic por_enable,
  input  logic rst_pin,
  output logic cpu_rst,
  output logic cpu_clk_en,
  output logic port_rst,
  output logic ale_force,
  output logic psen_force
);
  localparam int PW = $clog2(PHASES);
  localparam int CW = $clog2(POR_PERIODS + 1);
  localparam int HW = $clog2(MIN_HIGH + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [PW-1:0]          phase;
  logic [HW-1:0]          hi_cnt;
  logic [CW-1:0]          por_cnt;
  logic                   ext_rst;
  logic                   pin_s, slot, por_active;

  assign pin_s      = sync_q[SYNC_STAGES-1];
  assign slot       = (phase == PW'(SAMPLE_PHASE));
  assign por_active = por_enable && (por_cnt != CW'(POR_PERIODS));

  always_ff @(posedge clk or negedge pwr_good)
    if (!pwr_good) sync_q <= '0;
    else           sync_q <= {sync_q[SYNC_STAGES-2:0], rst_pin};

  always_ff @(posedge clk or negedge pwr_good)
    if (!pwr_good)                   phase <= '0;
    else if (phase == PW'(PHASES-1)) phase <= '0;
    else                             phase <= phase + 1'b1;

  always_ff @(posedge clk or negedge pwr_good)
    if (!pwr_good) begin
      hi_cnt  <= '0;
      ext_rst <= 1'b0;
    end else if (slot) begin
      if (!pin_s) begin
        hi_cnt  <= '0;
        ext_rst <= 1'b0;
      end else begin
        if (hi_cnt != HW'(MIN_HIGH)) hi_cnt <= hi_cnt + 1'b1;
        if (hi_cnt >= HW'(MIN_HIGH-1)) ext_rst <= 1'b1;
      end
    end

  always_ff @(posedge clk or negedge pwr_good)
    if (!pwr_good)                          por_cnt <= '0;
    else if (por_cnt != CW'(POR_PERIODS))   por_cnt <= por_cnt + 1'b1;

  assign cpu_rst    = ext_rst | por_active;
  assign cpu_clk_en = !por_active;
  assign port_rst   = rst_pin | cpu_rst;
  assign ale_force  = cpu_rst;
  assign psen_force = cpu_rst;

  // R1
  phase_wrap_chk: assert property (@(posedge clk) disable iff (!pwr_good)
    (phase == PW'(PHASES-1)) |=> (phase == '0));
  // R1
  rise_at_slot_chk: assert property (@(posedge clk) disable iff (!pwr_good)
    $rose(ext_rst) |-> $past(slot) && $past(pin_s));
  // R3
  fall_at_slot_chk: assert property (@(posedge clk) disable iff (!pwr_good)
    $fell(ext_rst) |-> $past(slot) && !$past(pin_s));
  // R6
  gated_in_reset_chk: assert property (@(posedge clk) disable iff (!pwr_good)
    !cpu_clk_en |-> cpu_rst);
  // R6
  por_bound_chk: assert property (@(posedge clk) disable iff (!pwr_good)
    por_cnt <= CW'(POR_PERIODS));
  // R7
  no_gate_chk: assert property (@(posedge clk) disable iff (!pwr_good)
    !por_enable |-> cpu_clk_en);
endmodule

// File: tb/mcu_reset_seq_tb.sv
module mcu_reset_seq_tb;
  localparam int POR = 1536;

  logic clk = 1'b0;
  logic pwr_good = 1'b0, por_enable = 1'b1, rst_pin = 1'b0;
  logic cpu_rst, cpu_clk_en, port_rst, ale_force, psen_force;
  int checks = 0, errors = 0;
  logic hist [0:2047];

  always #5 clk = ~clk;

  mcu_reset_seq u_dut (
    .clk(clk), .pwr_good(pwr_good), .por_enable(por_enable), .rst_pin(rst_pin),
    .cpu_rst(cpu_rst), .cpu_clk_en(cpu_clk_en), .port_rst(port_rst),
    .ale_force(ale_force), .psen_force(psen_force)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at %0t: actual %b expected %b", req, $time, act, exp);
    end
  endtask

  // R1 R2 R3 R6 R7 R9: pin pulse over edges [start, start+len) after power-good
  task automatic trial(input logic por, input int start, input int len, input int total);
    int k = 0, run = 0;
    logic ext = 1'b0, lvl, s, por_on;
    pwr_good = 1'b0; rst_pin = 1'b0; por_enable = por;
    @(negedge clk);
    pwr_good = 1'b1;
    for (int i = 0; i < total; i++) begin
      lvl = (k + 1 >= start) && (k + 1 < start + len);
      rst_pin = lvl; hist[k+1] = lvl;
      #1;
      por_on = por && (k < POR);
      chk("R4 port_rst", port_rst, lvl | ext | por_on);
      @(posedge clk); k++;
      if ((k - 1) % 12 == 9) begin
        s = (k >= 3) ? hist[k-2] : 1'b0;
        if (s) begin
          run = (run < 2) ? run + 1 : 2;
          if (run >= 2) ext = 1'b1;
        end else begin
          run = 0; ext = 1'b0;
        end
      end
      @(negedge clk);
      por_on = por && (k < POR);
      chk(por ? "R6 R9 cpu_rst" : "R1 R2 R3 R7 cpu_rst", cpu_rst, ext | por_on);
      chk(por ? "R6 clk_en" : "R7 clk_en", cpu_clk_en, !por_on);
      chk("R5 ale_force", ale_force, ext | por_on);
      chk("R5 psen_force", psen_force, ext | por_on);
    end
  endtask

  initial begin
    #(150000 * 10);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #12;
    // reset state, R8
    chk("R8 reset cpu_rst", cpu_rst, 1'b1);
    chk("R8 reset clk_en", cpu_clk_en, 1'b0);
    chk("R4 reset port_rst", port_rst, 1'b1);
    // R1 R2 R3 R7: sweep pulse start phase and length without power-on gating
    for (int st = 3; st < 15; st++)
      for (int ln = 1; ln <= 30; ln++)
        trial(1'b0, st, ln, st + ln + 40);
    // R6: power-on only; R9: pin across end of interval
    trial(1'b1, 5000, 1, POR + 30);
    trial(1'b1, 1490, 80, POR + 100);
    trial(1'b1, 1520, 12, POR + 60);
    // R8: asynchronous restart of the power-on count
    por_enable = 1'b1; rst_pin = 1'b0;
    pwr_good = 1'b0; @(negedge clk); pwr_good = 1'b1;
    repeat (POR + 5) @(negedge clk);
    chk("R8 clk_en before drop", cpu_clk_en, 1'b1);
    #2 pwr_good = 1'b0;
    #1;
    chk("R8 clk_en after drop", cpu_clk_en, 1'b0);
    chk("R8 cpu_rst after drop", cpu_rst, 1'b1);
    @(negedge clk); pwr_good = 1'b1;
    for (int n = 1; n <= POR; n++) begin
      @(negedge clk);
      chk("R8 restart clk_en", cpu_clk_en, n >= POR);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule